// File: doc/BRIEF.md
# Sector-Granular DMA Segment Splitter

This block sits between a DMA descriptor source and a storage device that only moves whole 512-byte sectors. Each descriptor names a byte address and a byte length in system memory. The splitter first hands over any bytes still pending from a sector it buffered earlier. It then asks the device to move the aligned bulk of the descriptor directly. If a partial sector is left at the end, it fetches that one sector into a local 512-byte buffer, writes only the needed leading bytes to memory and keeps the rest for the next descriptor. This lets a read transfer be cut into descriptors at arbitrary byte boundaries.

A transfer begins with a start pulse that loads the first sector and the sector count. In packet mode, the start value is a 2048-byte logical block number and each device sector is derived from the block and a byte offset within it. The transfer finishes only when no sectors remain and the carry buffer is empty. A device error aborts the transfer at once.

The controller is one state machine. Its states are: IDLE (no transfer), WAIT_DESC (offers to take a descriptor), CARRY (streams leftover buffered bytes), PLAN (splits the descriptor into bulk and tail), BULK_REQ and BULK_WAIT (bulk request and its completion), FILL_REQ and FILL_WAIT (single-sector fetch into the buffer), TAIL (writes tail bytes), NEXT (descriptor finished) and ABORT (error). Transitions:
- IDLE→WAIT_DESC on start.
- WAIT_DESC→CARRY when a descriptor is taken with a nonzero carry and a nonzero length; otherwise WAIT_DESC→PLAN.
- CARRY→PLAN when the carry or the length runs out.
- PLAN goes to BULK_REQ if there are whole sectors, else to FILL_REQ if there is a tail, else to NEXT.
- BULK_REQ→BULK_WAIT and FILL_REQ→FILL_WAIT on handshake.
- BULK_WAIT goes to FILL_REQ or NEXT on done.
- FILL_WAIT→TAIL on done.
- TAIL→NEXT after the last tail byte.
- BULK_WAIT and FILL_WAIT go to ABORT on error.
- NEXT goes to IDLE when the transfer is complete, else to WAIT_DESC.
- ABORT→IDLE.

Top module: `sector_dma_splitter`

## Requirements
- R1: After reset, busy, desc_ready, req_valid, mem_we, desc_done, xfer_done and xfer_err are all 0.
- R2: While no transfer is active, desc_ready stays 0 and a waiting descriptor is not taken. After a start pulse, that same descriptor is taken and serviced.
- R3: A descriptor's whole sectors are requested once, with req_fill=0, req_sector equal to the current sector, req_count equal to the sector count and req_addr equal to the byte address where the bulk begins (after any carry bytes).
- R4: A nonzero tail (length AND 0x1FF, within the remaining sectors) causes one request with req_fill=1, req_count=1, at the sector following the bulk. The device then streams 512 bytes into the buffer. Buffer bytes 0..tail−1 are written in ascending order to the addresses that follow the bulk.
- R5: After a tail, the carry count becomes 512−tail. The next descriptor first receives min(carry, length) bytes, taken from buffer offset 512−carry upward and written from its start address. Its address and length advance by that amount.
- R6: The current sector rises by the bulk count after each bulk and by one after each fill. The remaining count falls by the same amounts. Descriptor bytes beyond the remaining sectors are ignored.
- R7: desc_done pulses once per descriptor. xfer_done pulses with it only when the remaining count and the carry count are both zero. busy then falls; otherwise the block waits for the next descriptor.
- R8: In packet mode, the device sector is block×4 + (offset>>9). The offset advances by 512 per sector and wraps at 2048 into the next block. A start block B begins at sector 4B.
- R9: dev_err during a bulk or a fill pulses xfer_err, drops busy, writes no tail bytes and clears the carry. The next transfer's first descriptor receives no carry bytes.
- R10: While req_valid is 1 and req_ready is 0, req_valid, req_sector and req_count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_sector | input | LBA_W | First sector, or first logical block in packet mode |
| start_count | input | CNT_W | Number of sectors in the transfer |
| pkt_mode | input | 1 | 1 selects 2048-byte logical block addressing |
| desc_valid | input | 1 | Descriptor offered |
| desc_addr | input | ADDR_W | Descriptor byte address |
| desc_len | input | LEN_W | Descriptor byte length |
| desc_ready | output | 1 | Descriptor is taken this cycle if valid |
| req_valid | output | 1 | Sector request pending |
| req_ready | input | 1 | Device accepts the request |
| req_sector | output | LBA_W | First device sector of the request |
| req_count | output | CNT_W | Number of sectors |
| req_addr | output | ADDR_W | Memory byte address for the bulk, or tail start for a fill |
| req_fill | output | 1 | 1: sector goes to the local buffer; 0: device moves it to memory |
| dev_byte_valid | input | 1 | Fill byte present |
| dev_byte | input | 8 | Fill byte, sector order |
| dev_done | input | 1 | Request completed |
| dev_err | input | 1 | Request failed |
| mem_we | output | 1 | Partial-byte memory write |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 8 | Write byte |
| busy | output | 1 | Transfer active |
| desc_done | output | 1 | Descriptor finished |
| xfer_done | output | 1 | Transfer complete |
| xfer_err | output | 1 | Transfer aborted by a device error |

## Verification
A wrong carry count shows up on the first carry byte of the next descriptor: the address or the data on the memory port goes wrong within a cycle of the descriptor being taken, or xfer_done appears at the wrong descriptor. A wrong sector or remaining count shows up on the very next request's req_sector or req_count. In packet mode, an offset wrap error shows only when a request crosses into the next 2048-byte block, so a test is placed at that crossing. A lost error abort appears as carry bytes written at the start of the following transfer.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_DESC,
        ST_CARRY,
        ST_PLAN,
        ST_BULK_REQ,
        ST_BULK_WAIT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_TAIL,
        ST_NEXT,
        ST_ABORT
    } sds_state_e;

endpackage

// File: rtl/sds_sector_buf.sv
module sds_sector_buf #(
    parameter int SECT_LG = 9,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [SECT_LG-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [SECT_LG-1:0] raddr,
    output logic [DATA_W-1:0]  rdata
);
    localparam int DEPTH = 1 << SECT_LG;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/sds_sector_track.sv
module sds_sector_track #(
    parameter int LBA_W   = 32,
    parameter int CNT_W   = 16,
    parameter int NF_W    = 7,
    parameter int SECT_LG = 9,
    parameter int PKT_LG  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LBA_W-1:0] load_base,
    input  logic [CNT_W-1:0] load_count,
    input  logic             load_pkt,
    input  logic             adv,
    input  logic [NF_W-1:0]  adv_n,
    output logic [LBA_W-1:0] cur_sector,
    output logic [CNT_W-1:0] rem_count
);
    localparam int OFF_W  = PKT_LG;
    localparam int SUB_LG = PKT_LG - SECT_LG;
    localparam int STEP_W = NF_W + SECT_LG;
    localparam int SUM_W  = ((STEP_W > OFF_W) ? STEP_W : OFF_W) + 1;

    logic [LBA_W-1:0] blk_r;
    logic [OFF_W-1:0] off_r;
    logic             pkt_r;
    logic [CNT_W-1:0] rem_r;
    logic [SUM_W-1:0] sum;

    // byte offset after advancing by adv_n sectors, before the block wrap
    assign sum = SUM_W'(off_r) + (SUM_W'(adv_n) << SECT_LG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_r <= '0;
            off_r <= '0;
            pkt_r <= 1'b0;
            rem_r <= '0;
        end else if (load) begin
            blk_r <= load_base;
            off_r <= '0;
            pkt_r <= load_pkt;
            rem_r <= load_count;
        end else if (adv) begin
            rem_r <= rem_r - CNT_W'(adv_n);
            if (pkt_r) begin
                blk_r <= blk_r + LBA_W'(sum >> OFF_W);
                off_r <= sum[OFF_W-1:0];
            end else begin
                blk_r <= blk_r + LBA_W'(adv_n);
            end
        end
    end

    assign cur_sector = pkt_r ? ((blk_r << SUB_LG) + LBA_W'(off_r >> SECT_LG)) : blk_r;
    assign rem_count  = rem_r;

endmodule

// File: rtl/sector_dma_splitter.sv
module sector_dma_splitter
    import sds_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int CNT_W   = 16,
    parameter int LBA_W   = 32,
    parameter int SECT_LG = 9,
    parameter int PKT_LG  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LBA_W-1:0]  start_sector,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              pkt_mode,
    input  logic              desc_valid,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    output logic              desc_ready,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [LBA_W-1:0]  req_sector,
    output logic [CNT_W-1:0]  req_count,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_fill,
    input  logic              dev_byte_valid,
    input  logic [7:0]        dev_byte,
    input  logic              dev_done,
    input  logic              dev_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              busy,
    output logic              desc_done,
    output logic              xfer_done,
    output logic              xfer_err
);
    localparam int NF_W  = LEN_W - SECT_LG;
    localparam int CAP_W = CNT_W + SECT_LG;
    localparam int MAX_W = (CAP_W > LEN_W) ? CAP_W : LEN_W;

    sds_state_e state_r, state_n;

    logic [ADDR_W-1:0]  d_addr_r;
    logic [LEN_W-1:0]   d_len_r;
    logic [SECT_LG-1:0] carry_r;
    logic [SECT_LG-1:0] idx_r;
    logic [NF_W-1:0]    nf_r;
    logic [SECT_LG-1:0] tail_r;

    logic [LBA_W-1:0]   cur_sector;
    logic [CNT_W-1:0]   rem_count;
    logic               trk_load, trk_adv;
    logic [NF_W-1:0]    trk_n;

    logic [MAX_W-1:0]   cap_bytes, len_ext;
    logic [LEN_W-1:0]   eff_len;
    logic [NF_W-1:0]    nf_c;
    logic [SECT_LG-1:0] tail_c;

    logic               buf_we;
    logic [SECT_LG-1:0] buf_raddr;
    logic [7:0]         buf_rdata;

    logic               dev_ok;
    logic               carry_last, tail_last;

    // ---------------- split of the pending descriptor ----------------
    assign cap_bytes = MAX_W'(rem_count) << SECT_LG;
    assign len_ext   = MAX_W'(d_len_r);
    assign eff_len   = LEN_W'((len_ext < cap_bytes) ? len_ext : cap_bytes);
    assign nf_c      = eff_len[SECT_LG +: NF_W];
    assign tail_c    = eff_len[SECT_LG-1:0];

    assign dev_ok     = dev_done && !dev_err;
    assign carry_last = (carry_r == SECT_LG'(1)) || (d_len_r == LEN_W'(1));
    assign tail_last  = (idx_r == tail_r - SECT_LG'(1));

    // ---------------- sub-blocks ----------------
    assign trk_load = (state_r == ST_IDLE) && start;
    assign trk_adv  = ((state_r == ST_BULK_WAIT) || (state_r == ST_FILL_WAIT)) && dev_ok;
    assign trk_n    = (state_r == ST_BULK_WAIT) ? nf_r : NF_W'(1);

    sds_sector_track #(
        .LBA_W  (LBA_W),
        .CNT_W  (CNT_W),
        .NF_W   (NF_W),
        .SECT_LG(SECT_LG),
        .PKT_LG (PKT_LG)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_base (start_sector),
        .load_count(start_count),
        .load_pkt  (pkt_mode),
        .adv       (trk_adv),
        .adv_n     (trk_n),
        .cur_sector(cur_sector),
        .rem_count (rem_count)
    );

    assign buf_we    = (state_r == ST_FILL_WAIT) && dev_byte_valid;
    // carry bytes sit at the end of the buffer: offset 512 - carry
    assign buf_raddr = (state_r == ST_CARRY) ? (SECT_LG'(0) - carry_r) : idx_r;

    sds_sector_buf #(
        .SECT_LG(SECT_LG),
        .DATA_W (8)
    ) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(idx_r),
        .wdata(dev_byte),
        .raddr(buf_raddr),
        .rdata(buf_rdata)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= ST_IDLE;
        end else begin
            state_r <= state_n;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state_r;
        unique case (state_r)
            ST_IDLE:      if (start) state_n = ST_WAIT_DESC;
            ST_WAIT_DESC: if (desc_valid) begin
                              state_n = ((carry_r != '0) && (desc_len != '0)) ? ST_CARRY : ST_PLAN;
                          end
            ST_CARRY:     if (carry_last) state_n = ST_PLAN;
            ST_PLAN:      begin
                              if (nf_c != '0)        state_n = ST_BULK_REQ;
                              else if (tail_c != '0) state_n = ST_FILL_REQ;
                              else                   state_n = ST_NEXT;
                          end
            ST_BULK_REQ:  if (req_ready) state_n = ST_BULK_WAIT;
            ST_BULK_WAIT: begin
                              if (dev_err)     state_n = ST_ABORT;
                              else if (dev_done) state_n = (tail_r != '0) ? ST_FILL_REQ : ST_NEXT;
                          end
            ST_FILL_REQ:  if (req_ready) state_n = ST_FILL_WAIT;
            ST_FILL_WAIT: begin
                              if (dev_err)       state_n = ST_ABORT;
                              else if (dev_done) state_n = ST_TAIL;
                          end
            ST_TAIL:      if (tail_last) state_n = ST_NEXT;
            ST_NEXT:      state_n = ((rem_count == '0) && (carry_r == '0)) ? ST_IDLE : ST_WAIT_DESC;
            ST_ABORT:     state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // ---------------- working registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_addr_r <= '0;
            d_len_r  <= '0;
            carry_r  <= '0;
            idx_r    <= '0;
            nf_r     <= '0;
            tail_r   <= '0;
        end else begin
            unique case (state_r)
                ST_WAIT_DESC: if (desc_valid) begin
                                  d_addr_r <= desc_addr;
                                  d_len_r  <= desc_len;
                              end
                ST_CARRY:     begin
                                  d_addr_r <= d_addr_r + ADDR_W'(1);
                                  d_len_r  <= d_len_r - LEN_W'(1);
                                  carry_r  <= carry_r - SECT_LG'(1);
                              end
                ST_PLAN:      begin
                                  nf_r   <= nf_c;
                                  tail_r <= tail_c;
                              end
                ST_BULK_WAIT: if (dev_ok) d_addr_r <= d_addr_r + (ADDR_W'(nf_r) << SECT_LG);
                ST_FILL_REQ:  idx_r <= '0;
                ST_FILL_WAIT: begin
                                  if (dev_done || dev_err) idx_r <= '0;
                                  else if (dev_byte_valid) idx_r <= idx_r + SECT_LG'(1);
                              end
                ST_TAIL:      begin
                                  idx_r <= idx_r + SECT_LG'(1);
                                  if (tail_last) carry_r <= SECT_LG'(0) - tail_r;
                              end
                ST_ABORT:     carry_r <= '0;
                default:      ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy       = (state_r != ST_IDLE);
        desc_ready = (state_r == ST_WAIT_DESC);
        req_valid  = (state_r == ST_BULK_REQ) || (state_r == ST_FILL_REQ);
        req_fill   = (state_r == ST_FILL_REQ);
        req_sector = cur_sector;
        req_count  = req_fill ? CNT_W'(1) : CNT_W'(nf_r);
        req_addr   = d_addr_r;
        mem_we     = (state_r == ST_CARRY) || (state_r == ST_TAIL);
        mem_addr   = (state_r == ST_TAIL) ? (d_addr_r + ADDR_W'(idx_r)) : d_addr_r;
        mem_data   = buf_rdata;
        desc_done  = (state_r == ST_NEXT);
        xfer_done  = (state_r == ST_NEXT) && (rem_count == '0) && (carry_r == '0);
        xfer_err   = (state_r == ST_ABORT);
    end

endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
    parameter int CNT_W   = 16,
    parameter int LBA_W   = 32,
    parameter int SECT_LG = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               desc_ready,
    input logic               req_valid,
    input logic               req_ready,
    input logic [LBA_W-1:0]   req_sector,
    input logic [CNT_W-1:0]   req_count,
    input logic               req_fill,
    input logic               mem_we,
    input logic               desc_done,
    input logic               xfer_done,
    input logic               xfer_err,
    input logic [SECT_LG-1:0] carry_cnt
);

    AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !desc_ready); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_sector) && $stable(req_count))); // R10

    AST_FILL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fill) |-> (req_count == CNT_W'(1))); // R4

    AST_DONE_WITH_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> desc_done); // R7

    AST_DONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !busy); // R7

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> (!busy && (carry_cnt == '0))); // R9

    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && xfer_err)); // R9

    AST_MEM_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && !req_valid)); // R5

endmodule

bind sector_dma_splitter sds_checker #(
    .CNT_W  (CNT_W),
    .LBA_W  (LBA_W),
    .SECT_LG(SECT_LG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .desc_ready(desc_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_sector(req_sector),
    .req_count (req_count),
    .req_fill  (req_fill),
    .mem_we    (mem_we),
    .desc_done (desc_done),
    .xfer_done (xfer_done),
    .xfer_err  (xfer_err),
    .carry_cnt (carry_r)
);

// File: tb/tb_sector_dma_splitter.sv
module tb_sector_dma_splitter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_sector = '0;
    logic [15:0] start_count = '0;
    logic        pkt_mode = 1'b0;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_addr = '0;
    logic [15:0] desc_len = '0;
    logic        desc_ready;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_sector;
    logic [15:0] req_count;
    logic [31:0] req_addr;
    logic        req_fill;
    logic        dev_byte_valid = 1'b0;
    logic [7:0]  dev_byte = '0;
    logic        dev_done = 1'b0;
    logic        dev_err = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;
    logic        busy, desc_done, xfer_done, xfer_err;

    always #5 clk = ~clk;

    sector_dma_splitter dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_sector(start_sector),
        .start_count(start_count), .pkt_mode(pkt_mode), .desc_valid(desc_valid),
        .desc_addr(desc_addr), .desc_len(desc_len), .desc_ready(desc_ready),
        .req_valid(req_valid), .req_ready(req_ready), .req_sector(req_sector),
        .req_count(req_count), .req_addr(req_addr), .req_fill(req_fill),
        .dev_byte_valid(dev_byte_valid), .dev_byte(dev_byte), .dev_done(dev_done),
        .dev_err(dev_err), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .busy(busy), .desc_done(desc_done), .xfer_done(xfer_done), .xfer_err(xfer_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog R7", 64'(cyc), 64'd150000);
            finish_up();
        end
    end

    function automatic logic [7:0] pat(input logic [31:0] s, input int i);
        return 8'(s * 13 + 32'(i) * 3 + 32'(i >> 8));
    endfunction

    // ---------------- reference model and scoreboard ----------------
    logic [31:0] m_base = '0;
    bit          m_pkt = 1'b0;
    int          m_pos = 0, m_rem = 0, m_carry = 0;
    logic [31:0] m_fsec = '0;

    logic [31:0] q_ma[$];
    logic [7:0]  q_md[$];
    string       q_mt[$];
    logic [31:0] q_rs[$];
    logic [15:0] q_rc[$];
    logic [31:0] q_ra[$];
    bit          q_rf[$];
    string       q_rt[$];

    function automatic logic [31:0] map_sec(input int pos);
        return m_pkt ? (m_base * 4 + 32'(pos)) : (m_base + 32'(pos));
    endfunction

    task automatic push_req(input logic [31:0] s, input int c, input logic [31:0] a, input bit f, input string t);
        q_rs.push_back(s); q_rc.push_back(16'(c)); q_ra.push_back(a); q_rf.push_back(f); q_rt.push_back(t);
    endtask

    task automatic expect_desc(input logic [31:0] a0, input int len0, input bit fail_fill);
        logic [31:0] a;
        logic [31:0] s;
        int len, k, eff, nf, tl;
        a = a0; len = len0;
        k = (m_carry < len) ? m_carry : len;
        for (int j = 0; j < k; j++) begin
            q_ma.push_back(a + 32'(j));
            q_md.push_back(pat(m_fsec, 512 - m_carry + j));
            q_mt.push_back("R5 carry byte");
        end
        a += 32'(k); len -= k; m_carry -= k;
        eff = (len < m_rem * 512) ? len : m_rem * 512;
        nf = eff / 512; tl = eff % 512;
        if (nf > 0) begin
            push_req(map_sec(m_pos), nf, a, 1'b0, m_pkt ? "R8 packet bulk" : "R3 bulk");
            m_pos += nf; m_rem -= nf; a += 32'(nf * 512);
        end
        if (tl > 0) begin
            s = map_sec(m_pos);
            push_req(s, 1, a, 1'b1, m_pkt ? "R8 packet fill" : "R4 fill");
            if (fail_fill) begin
                m_carry = 0;
            end else begin
                for (int j = 0; j < tl; j++) begin
                    q_ma.push_back(a + 32'(j)); q_md.push_back(pat(s, j)); q_mt.push_back("R4 tail byte");
                end
                m_fsec = s; m_pos++; m_rem--; m_carry = 512 - tl;
            end
        end
    endtask

    // ---------------- device model ----------------
    int  stall_n = 0;
    bit  inj_err = 1'b0;

    always begin
        logic [31:0] s0;
        bit          f0;
        @(negedge clk);
        if (rst_n && req_valid) begin
            s0 = req_sector; f0 = req_fill;
            for (int i = 0; i < stall_n; i++) begin
                @(negedge clk);
                check(req_valid && (req_sector == s0), "R10 request held", {32'(req_valid), req_sector}, {32'd1, s0});
            end
            req_ready = 1'b1;
            if (q_rs.size() == 0) begin
                check(1'b0, "R3 unexpected request", 64'(req_sector), 64'hFFFFFFFF);
            end else begin
                check((req_sector == q_rs[0]) && (req_count == q_rc[0]) && (req_addr == q_ra[0]) && (req_fill == q_rf[0]),
                      q_rt[0], {req_sector, req_addr[15:0], req_count[14:0], req_fill},
                      {q_rs[0], q_ra[0][15:0], q_rc[0][14:0], q_rf[0]});
                void'(q_rs.pop_front()); void'(q_rc.pop_front()); void'(q_ra.pop_front());
                void'(q_rf.pop_front()); void'(q_rt.pop_front());
            end
            @(negedge clk);
            req_ready = 1'b0;
            if (f0) begin
                for (int i = 0; i < 512; i++) begin
                    if (inj_err && i == 10) break;
                    dev_byte_valid = 1'b1; dev_byte = pat(s0, i);
                    @(negedge clk);
                end
                dev_byte_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
            if (inj_err && f0) begin
                dev_err = 1'b1; inj_err = 1'b0;
            end else begin
                dev_done = 1'b1;
            end
            @(negedge clk);
            dev_err = 1'b0; dev_done = 1'b0;
        end
    end

    // ---------------- monitor ----------------
    int c_desc = 0, c_done = 0, c_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (desc_done) c_desc++;
            if (xfer_done) c_done++;
            if (xfer_err)  c_err++;
            if (mem_we) begin
                if (q_ma.size() == 0) begin
                    check(1'b0, "R9 unexpected memory write", 64'(mem_addr), 64'hFFFFFFFF);
                end else begin
                    check((mem_addr == q_ma[0]) && (mem_data == q_md[0]), q_mt[0],
                          {mem_addr, 24'd0, mem_data}, {q_ma[0], 24'd0, q_md[0]});
                    void'(q_ma.pop_front()); void'(q_md.pop_front()); void'(q_mt.pop_front());
                end
            end
        end
    end

    // ---------------- driver tasks (entered at a falling edge) ----------------
    task automatic start_xfer(input logic [31:0] base, input int cnt, input bit pkt);
        m_base = base; m_pkt = pkt; m_pos = 0; m_rem = cnt;
        start = 1'b1; start_sector = base; start_count = 16'(cnt); pkt_mode = pkt;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drive_desc();
        desc_valid = 1'b1;
        while (!desc_ready) @(negedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic wait_desc_end(input int d0, input int e0, input int n0, input bit exp_done, input string tag);
        while (c_desc == d0 && c_err == e0) @(negedge clk);
        @(negedge clk);
        check((c_done - n0) == int'(exp_done), tag, 64'(c_done - n0), 64'(exp_done));
        check(busy == !exp_done, "R7 busy after descriptor", 64'(busy), 64'(!exp_done));
    endtask

    task automatic run_desc(input logic [31:0] a, input int len, input string tag);
        int d0, e0, n0;
        bit ed;
        d0 = c_desc; e0 = c_err; n0 = c_done;
        expect_desc(a, len, 1'b0);
        ed = (m_rem == 0) && (m_carry == 0);
        desc_addr = a; desc_len = 16'(len);
        drive_desc();
        wait_desc_end(d0, e0, n0, ed, tag);
    endtask

    initial begin
        int d0, e0, n0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !desc_ready && !req_valid && !mem_we, "R1 reset outputs",
              {busy, desc_ready, req_valid, mem_we}, 64'd0);
        check(!desc_done && !xfer_done && !xfer_err, "R1 reset pulses",
              {desc_done, xfer_done, xfer_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: descriptor offered while idle is not taken
        desc_addr = 32'h1000; desc_len = 16'h0300; desc_valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!desc_ready && !busy && !req_valid, "R2 held while idle",
                  {desc_ready, busy, req_valid}, 64'd0);
        end
        d0 = c_desc; e0 = c_err; n0 = c_done;
        start_xfer(32'd100, 6, 1'b0);
        expect_desc(32'h1000, 'h300, 1'b0);
        drive_desc();
        wait_desc_end(d0, e0, n0, 1'b0, "R2 held descriptor serviced, R7 not done");
        check(m_carry == 256, "R5 model carry", 64'(m_carry), 64'd256);

        // R5: short descriptor served wholly from carry
        run_desc(32'h2000, 100, "R5 carry-only descriptor");
        // R5, R3, R4: carry then bulk then tail
        run_desc(32'h3000, 'h500, "R4 mixed descriptor");
        // R6: oversize descriptor capped by remaining sectors, transfer ends
        run_desc(32'h5000, 'h1000, "R6 capped descriptor, R7 done");
        repeat (4) @(negedge clk);
        check(!busy && !mem_we && !req_valid, "R6 excess bytes ignored", {busy, mem_we, req_valid}, 64'd0);

        // R8 and R10: packet mode with request stalls, crosses a block boundary
        stall_n = 2;
        start_xfer(32'd10, 5, 1'b1);
        run_desc(32'h8000, 'h700, "R8 packet first descriptor");
        run_desc(32'h9000, 'h300, "R8 packet block crossing, R7 done");
        stall_n = 0;

        // R9: device error during a fill aborts the transfer
        start_xfer(32'd200, 4, 1'b0);
        d0 = c_desc; e0 = c_err; n0 = c_done;
        expect_desc(32'hA000, 'h280, 1'b1);
        inj_err = 1'b1;
        desc_addr = 32'hA000; desc_len = 16'h0280;
        drive_desc();
        while (c_err == e0 && c_desc == d0) @(negedge clk);
        @(negedge clk);
        check(c_err - e0 == 1, "R9 error pulse", 64'(c_err - e0), 64'd1);
        check(!busy && !desc_ready, "R9 idle after error", {busy, desc_ready}, 64'd0);
        check(c_done == n0, "R9 no completion", 64'(c_done - n0), 64'd0);

        // R9: next transfer receives no carry bytes
        start_xfer(32'd300, 1, 1'b0);
        run_desc(32'hB000, 'h200, "R9 fresh transfer, R7 done");

        repeat (5) @(negedge clk);
        check(q_ma.size() == 0, "R4 memory writes drained", 64'(q_ma.size()), 64'd0);
        check(q_rs.size() == 0, "R3 requests drained", 64'(q_rs.size()), 64'd0);
        finish_up();
    end

endmodule